// File: doc/BRIEF.md
# Serial flash status register controller

This block is the device-side status-register logic of a serial flash. It sits behind a mode-0 SPI slave port (chip select active low, data sampled on the rising serial clock and shifted out on the falling one) and decodes four commands. The first enables non-volatile writes. The second enables a one-shot volatile write. The third writes the status byte. The fourth reads it back.

The block holds two copies of the six writable status bits. The volatile copy is what reads return. The non-volatile copy survives a power cycle. A non-volatile write updates both copies and starts a self-timed cycle that lasts a parameterised number of system clocks. During that cycle BUSY is set and only the read command is honoured. A volatile write updates the volatile copy at once and never raises BUSY.

The SPI pins are sampled in the system clock domain, so the serial clock must run several times slower than `clk`. Two reset inputs are provided. `por_n` models the first power-up with factory-default contents, and `rst_n` models a power cycle.

Top module: `spi_status_ctrl`

## Requirements
- R1: Opcode 0x06, with chip select rising after exactly 8 bits, sets WEL (status bit 1) and discards any pending volatile enable.
- R2: Opcode 0x05 returns the status byte {writable[7:2], WEL, BUSY} MSB first. Each bit is driven after a falling clock edge from bit 9 of the frame onward. Each bit reflects the live status, and the byte repeats while chip select stays low.
- R3: Opcode 0x01 with WEL set and chip select rising after exactly 16 bits writes data bits 7..2 into both copies. Bits 1..0 of the data have no effect.
- R4: A 0x01 frame ended at any bit count other than 16 writes nothing, and it leaves WEL unchanged.
- R5: A 0x01 frame with WEL clear and no volatile enable pending leaves the status unchanged and does not raise BUSY.
- R6: A non-volatile write holds BUSY at 1 for exactly TW_CYCLES clocks. When BUSY falls, WEL is cleared.
- R7: While BUSY is 1, every command except 0x05 is ignored. Reads still work during this time.
- R8: Opcode 0x50 (8 bits) arms a volatile enable. The next 0x01 frame of 16 bits then updates only the volatile copy, with BUSY staying 0 and WEL unchanged.
- R9: A volatile enable is consumed by the next 0x01 frame. Any other completed frame of 8 or more bits clears it.
- R10: `por_n` low clears both copies, WEL, BUSY and the volatile enable. `rst_n` low reloads the volatile copy from the non-volatile copy and clears WEL, BUSY and the enable.
- R11: `miso` is 0 whenever chip select was high at the previous clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; times the write cycle and samples the SPI pins |
| por_n | input | 1 | Power-on reset to factory state, active low, synchronous |
| rst_n | input | 1 | Power-cycle reset, active low, synchronous |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | SPI serial data in |
| miso | output | 1 | SPI serial data out |

## Verification
The bench builds the block with TW_CYCLES set to 120. At that length, a write command and an enable sent straight after a non-volatile write both land inside the busy window. A three-byte status poll started next then spans the falling edge of BUSY. This shows the live per-bit status, the clearing of WEL and the rejection of commands during the cycle, all within one short run. Aborted frames at 15 and 17 bits, volatile enables that get cancelled or consumed, and both reset kinds are then checked against a behavioural model that tracks time in clock counts.

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl #(
  parameter int TW_CYCLES = 5000
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int CW = $clog2(TW_CYCLES + 1);
  localparam logic [CW-1:0] TW_L = CW'(TW_CYCLES);
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_VWREN = 8'h50;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  logic          sck_q, cs_q;
  logic [4:0]    cnt;
  logic [7:0]    sh, op;
  logic [7:2]    nv, vol;
  logic          wel, busy, ve;
  logic [CW-1:0] tcnt;
  logic [2:0]    ridx;
  logic          miso_r;

  wire sck_rise = sck & ~sck_q & ~cs_n;
  wire sck_fall = ~sck & sck_q & ~cs_n;
  wire cs_rise  = cs_n & ~cs_q;
  wire has_op   = cnt >= 5'd8;
  wire [7:0] status = {vol, wel, busy};

  assign miso = miso_r;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; cnt <= '0; sh <= '0; op <= '0;
      nv <= '0; vol <= '0; wel <= 1'b0; busy <= 1'b0; ve <= 1'b0;
      tcnt <= '0; ridx <= 3'd7; miso_r <= 1'b0;
    end else if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; cnt <= '0; sh <= '0; op <= '0;
      vol <= nv; wel <= 1'b0; busy <= 1'b0; ve <= 1'b0;
      tcnt <= '0; ridx <= 3'd7; miso_r <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        cnt <= '0; ridx <= 3'd7; miso_r <= 1'b0;
      end else begin
        if (sck_rise) begin
          sh <= {sh[6:0], mosi};
          if (cnt != 5'd31) cnt <= cnt + 5'd1;
          if (cnt == 5'd7) op <= {sh[6:0], mosi};
        end
        if (sck_fall && has_op && op == OP_RDSR) begin
          miso_r <= status[ridx];
          ridx   <= ridx - 3'd1;
        end
      end
      if (busy) begin
        if (tcnt == CW'(1)) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end
        tcnt <= tcnt - CW'(1);
      end else if (cs_rise && has_op) begin
        if (op == OP_WREN && cnt == 5'd8) begin
          wel <= 1'b1;
          ve  <= 1'b0;
        end else if (op == OP_VWREN && cnt == 5'd8) begin
          ve <= 1'b1;
        end else begin
          ve <= 1'b0;
          if (op == OP_WRSR && cnt == 5'd16) begin
            if (ve) begin
              vol <= sh[7:2];
            end else if (wel) begin
              vol  <= sh[7:2];
              nv   <= sh[7:2];
              busy <= 1'b1;
              tcnt <= TW_L;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_status_ctrl_chk.sv
module spi_status_ctrl_chk #(
  parameter int TW_CYCLES = 5000,
  parameter int CW = 13
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          cs_n,
  input logic          miso,
  input logic          busy,
  input logic          wel,
  input logic          ve,
  input logic [7:2]    nv,
  input logic [CW-1:0] tcnt
);
  // R6
  busy_window_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    busy |-> (tcnt != '0 && int'(tcnt) <= TW_CYCLES));
  // R6
  wel_drop_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $fell(busy) |-> !wel);
  // R5
  busy_needs_wel_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(busy) |-> $past(wel));
  // R7
  nv_frozen_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $past(busy) |-> $stable(nv));
  // R8
  venable_idle_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(ve) |-> !busy);
  // R11
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $past(cs_n) |-> !miso);
endmodule

bind spi_status_ctrl spi_status_ctrl_chk #(.TW_CYCLES(TW_CYCLES), .CW(CW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .cs_n(cs_n), .miso(miso),
  .busy(busy), .wel(wel), .ve(ve), .nv(nv), .tcnt(tcnt)
);

// File: tb/test_spi_status_ctrl.sv
module test_spi_status_ctrl;
  localparam int TW = 120;
  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b1, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  wire  miso;
  int total = 0, bad = 0, cyc = 0;
  logic [7:2] m_nv = '0, m_vol = '0;
  logic m_wel = 1'b0, m_ve = 1'b0, m_pend = 1'b0;
  int busy_end = -1;
  logic cs_prev = 1'b1;

  spi_status_ctrl #(.TW_CYCLES(TW)) i_spi_status_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R11: checked on every clock
  always @(posedge clk) begin
    #2;
    if (por_n && rst_n && cs_n && cs_prev) chk(miso == 1'b0, "R11", miso, 0);
    cs_prev = cs_n;
  end

  function automatic logic busy_at(input int xm1);
    return xm1 < busy_end;
  endfunction

  task automatic settle(input int xm1);
    if (m_pend && !busy_at(xm1)) begin m_wel = 1'b0; m_pend = 1'b0; end
  endtask

  task automatic frame_end(input int nb, input logic [7:0] op, input logic [7:0] dat);
    int xm1 = cyc - 1;
    settle(xm1);
    if (busy_at(xm1) || nb < 8) return;
    if (op == 8'h06 && nb == 8) begin m_wel = 1'b1; m_ve = 1'b0; end
    else if (op == 8'h50 && nb == 8) m_ve = 1'b1;
    else begin
      if (op == 8'h01 && nb == 16) begin
        if (m_ve) m_vol = dat[7:2];
        else if (m_wel) begin
          m_vol = dat[7:2]; m_nv = dat[7:2];
          busy_end = cyc + TW; m_pend = 1'b1;
        end
      end
      m_ve = 1'b0;
    end
  endtask

  task automatic xfer(input int nb, input logic [7:0] op, input logic [7:0] dat, input string req);
    logic e;
    @(negedge clk) cs_n = 1'b0; sck = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      sck = 1'b0;
      mosi = (i < 8) ? op[7-i] : (i < 16 ? dat[15-i] : 1'b0);
      e = 1'b0;
      if (i >= 8 && op == 8'h05) begin
        logic [7:0] st;
        settle(cyc);
        st = {m_vol, m_wel, busy_at(cyc)};
        e = st[7 - ((i - 8) % 8)];
      end
      @(negedge clk); @(negedge clk);
      if (i >= 8 && op == 8'h05) chk(miso == e, req, miso, e);
      sck = 1'b1;
      @(negedge clk);
    end
    @(negedge clk) cs_n = 1'b1; sck = 1'b0;
    @(posedge clk); #1;
    frame_end(nb, op, dat);
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input int bytes, input string req);
    xfer(8 + 8 * bytes, 8'h05, 8'h00, req);
  endtask

  task automatic do_por;
    @(negedge clk) por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    m_nv = '0; m_vol = '0; m_wel = 1'b0; m_ve = 1'b0; m_pend = 1'b0; busy_end = -1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_por();
    chk(miso == 1'b0, "R10", miso, 0);
    rd(1, "R10 reset state");
    xfer(16, 8'h01, 8'hFF, "R5");
    rd(1, "R5 write without enable");
    xfer(8, 8'h06, 8'h00, "R1");
    rd(2, "R1 R2 WEL and repeat");
    xfer(15, 8'h01, 8'hFF, "R4");
    xfer(17, 8'h01, 8'hFF, "R4");
    rd(1, "R4 aborted writes");
    xfer(16, 8'h01, 8'hFF, "R3");
    xfer(16, 8'h01, 8'h00, "R7");
    xfer(8, 8'h50, 8'h00, "R7");
    rd(3, "R6 R7 busy poll");
    repeat (TW) @(negedge clk);
    rd(1, "R3 R6 after cycle");
    xfer(8, 8'h50, 8'h00, "R8");
    xfer(16, 8'h01, 8'h27, "R8");
    rd(1, "R8 volatile write");
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_vol = m_nv; m_wel = 1'b0; m_ve = 1'b0; m_pend = 1'b0; busy_end = -1;
    repeat (2) @(negedge clk);
    rd(1, "R10 power cycle restore");
    xfer(8, 8'h50, 8'h00, "R9");
    rd(1, "R9 read cancels enable");
    xfer(16, 8'h01, 8'h00, "R9");
    rd(1, "R9 write ignored");
    xfer(8, 8'h50, 8'h00, "R9");
    xfer(8, 8'h06, 8'h00, "R9");
    xfer(16, 8'h01, 8'h13, "R9");
    rd(1, "R9 R6 enable replaced");
    repeat (TW + 10) @(negedge clk);
    rd(1, "R3 R6 final");
    do_por();
    rd(1, "R10 factory clear");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule